// File: doc/BRIEF.md
# Audio Serial Port Register and Interrupt Block

This block is the memory-mapped control and status front end of a stereo or time-division audio serial controller. A simple 32-bit register bus with byte addresses and word-aligned accesses reaches a command register, a mode register, a status register with separate clear and set aliases, interrupt enable, disable and mask registers, the receive and transmit holding words, and a read-only version word.

The block owns the enable state of the receiver, the transmitter and the clock generator. It latches sticky receive-overrun and transmit-underrun flags, both as summary bits and as one flag per channel. It drives one level-sensitive interrupt request. The serializer and the clock divider sit outside. They deliver received words with a strobe, take transmit words with a strobe, and report per-channel errors on pulse inputs.

Byte offsets: command 0x00, mode 0x04, status 0x08, status-clear 0x0C, status-set 0x10, interrupt-enable 0x14, interrupt-disable 0x18, interrupt-mask 0x1C, receive holding 0x20, transmit holding 0x24, version 0x28. Reads return data combinationally in the same cycle as `busSel`. Writes take effect at the next clock edge.

Top module: `audio_port_regs`

## Requirements
- R1: After reset the status word reads 0x0000_0020 (only transmit-ready set), the mask and mode read 0, all three enable outputs are low and `irq` is low.
- R2: The mode register (0x04) is fully read/write, and its value appears on `modeOut`.
- R3: Command writes (0x00) act as one-shot strobes. Bit 0 enables the receiver, bit 2 the clock generator and bit 4 the transmitter. Status bit 0 mirrors the receiver enable and status bit 4 the transmitter enable.
- R4: Bit 1 disables the receiver, bit 3 the clock generator and bit 5 the transmitter. When an enable bit and its disable bit are written together, the disable wins.
- R5: While the receiver is enabled, an `rxWordValid` strobe loads the receive holding word (0x20) and sets receive-ready (status bit 1). While the receiver is disabled, the strobe is ignored. A bus read of 0x20 returns the word and clears receive-ready.
- R6: A received word that arrives while receive-ready is still set, with no read of 0x20 in the same cycle, sets the sticky receive-overrun bit (status bit 2).
- R7: A pulse on `rxOvrChIn[c]` sets per-channel flag status bit 8+c and the overrun summary. A pulse on `txUndChIn[c]` sets status bit 20+c and the underrun summary (bit 6). A write to 0x0C clears each summary bit and each per-channel bit that is 1 in the written mask, and leaves all other bits unchanged.
- R8: A write to status-set (0x10) sets the sticky flags (bits 2, 6, 15:8, 27:20) that are 1 in the written mask. When an error event and a clear fall in the same cycle, the flag stays set.
- R9: Writing 1s to 0x14 sets mask bits and writing 1s to 0x18 clears them. Only bits 1, 2, 5 and 6 can be set. The mask reads back at 0x1C, and `irq` is high exactly while status AND mask is nonzero.
- R10: Transmit-ready (status bit 5) is set while the transmit holding word is empty. A write to 0x24 stores the word on `txWord` and clears transmit-ready. A `txTake` strobe with the transmitter enabled empties the word. A `txTake` while already empty sets transmit-underrun (bit 6).
- R11: The version word reads the `VERSION` parameter. Write-only offsets (0x00, 0x0C, 0x10, 0x14, 0x18, 0x24), unmapped offsets and misaligned addresses read 0.
- R12: Command bit 7 (software reset) returns every register and flag to its R1 value at the next clock edge, and takes priority over all other bits and events in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the access cycle |
| rxWordValid | input | 1 | Serializer delivers a received word |
| rxWordIn | input | 32 | Received word |
| rxOvrChIn | input | NUM_CH | Per-channel receive overrun pulses |
| txTake | input | 1 | Serializer takes the transmit word |
| txUndChIn | input | NUM_CH | Per-channel transmit underrun pulses |
| txWord | output | 32 | Transmit holding word |
| modeOut | output | 32 | Mode register contents |
| rxEnabled | output | 1 | Receiver enable state |
| txEnabled | output | 1 | Transmitter enable state |
| clkGenEnabled | output | 1 | Clock generator enable state |
| irq | output | 1 | Level interrupt request |

## Verification
The bound checker watches the following on every cycle:
- the disable-wins rule for the receiver;
- the one-cycle effect of software reset;
- the clearing of receive-ready by a holding-word read;
- the clearing of transmit-ready by a transmit write;
- overrun latching on a back-to-back received word;
- zero data on unmapped reads.

Only the bench scenarios can show the other behaviours:
- per-channel flags surviving a clear that names only the summary bit;
- the set alias;
- the mask limits and interrupt level across enable and disable writes;
- the underrun that comes from taking an empty word;
- the receiver ignoring words while disabled.

// File: rtl/aport_pkg.sv
package aport_pkg;
  // word indexes (byte offset / 4)
  localparam int IDX_CMD  = 0;
  localparam int IDX_MODE = 1;
  localparam int IDX_STAT = 2;
  localparam int IDX_CLR  = 3;
  localparam int IDX_SET  = 4;
  localparam int IDX_IEN  = 5;
  localparam int IDX_IDIS = 6;
  localparam int IDX_MASK = 7;
  localparam int IDX_RHR  = 8;
  localparam int IDX_THR  = 9;
  localparam int IDX_VER  = 10;

  // status bit positions
  localparam int ST_RXEN  = 0;
  localparam int ST_RXRDY = 1;
  localparam int ST_RXOVR = 2;
  localparam int ST_TXEN  = 4;
  localparam int ST_TXRDY = 5;
  localparam int ST_TXUND = 6;
  localparam int RXCH_LSB = 8;
  localparam int TXCH_LSB = 20;
  localparam int MAX_CH   = 8;

  // command bit positions
  localparam int CMD_RXON  = 0;
  localparam int CMD_RXOFF = 1;
  localparam int CMD_CKON  = 2;
  localparam int CMD_CKOFF = 3;
  localparam int CMD_TXON  = 4;
  localparam int CMD_TXOFF = 5;
  localparam int CMD_RESET = 7;

  localparam logic [31:0] IRQ_BITS = 32'h0000_0066;

  typedef enum logic [2:0] {
    RD_ZERO, RD_MODE, RD_STATUS, RD_MASK, RD_RHR, RD_VERSION
  } rdSel_e;

  typedef struct packed {
    logic   cmdWr;
    logic   modeWr;
    logic   clrWr;
    logic   setWr;
    logic   ienWr;
    logic   idisWr;
    logic   thrWr;
    logic   rhrRd;
    rdSel_e rdSel;
  } regStrobes_t;
endpackage

// File: rtl/aport_ctrl.sv
module aport_ctrl
  import aport_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrobes_t       strobes
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  logic             aligned;
  logic             wrAcc;
  logic             rdAcc;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign aligned = (busAddr[1:0] == 2'b00);
  assign wrAcc   = busSel && busWrite && aligned;
  assign rdAcc   = busSel && !busWrite && aligned;

  always_comb begin
    strobes        = '0;
    strobes.rdSel  = RD_ZERO;
    strobes.cmdWr  = wrAcc && (wordIdx == IDX_W'(IDX_CMD));
    strobes.modeWr = wrAcc && (wordIdx == IDX_W'(IDX_MODE));
    strobes.clrWr  = wrAcc && (wordIdx == IDX_W'(IDX_CLR));
    strobes.setWr  = wrAcc && (wordIdx == IDX_W'(IDX_SET));
    strobes.ienWr  = wrAcc && (wordIdx == IDX_W'(IDX_IEN));
    strobes.idisWr = wrAcc && (wordIdx == IDX_W'(IDX_IDIS));
    strobes.thrWr  = wrAcc && (wordIdx == IDX_W'(IDX_THR));
    strobes.rhrRd  = rdAcc && (wordIdx == IDX_W'(IDX_RHR));
    if (rdAcc) begin
      if      (wordIdx == IDX_W'(IDX_MODE)) strobes.rdSel = RD_MODE;
      else if (wordIdx == IDX_W'(IDX_STAT)) strobes.rdSel = RD_STATUS;
      else if (wordIdx == IDX_W'(IDX_MASK)) strobes.rdSel = RD_MASK;
      else if (wordIdx == IDX_W'(IDX_RHR))  strobes.rdSel = RD_RHR;
      else if (wordIdx == IDX_W'(IDX_VER))  strobes.rdSel = RD_VERSION;
    end
  end
endmodule

// File: rtl/aport_datapath.sv
module aport_datapath
  import aport_pkg::*;
#(
  parameter int          NUM_CH  = 8,
  parameter logic [31:0] VERSION = 32'h0000_0210
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobes_t       strobes,
  input  logic [31:0]       wdata,
  input  logic              rxWordValid,
  input  logic [31:0]       rxWordIn,
  input  logic [NUM_CH-1:0] rxOvrChIn,
  input  logic              txTake,
  input  logic [NUM_CH-1:0] txUndChIn,
  output logic [31:0]       rdata,
  output logic [31:0]       statusVec,
  output logic [31:0]       txWord,
  output logic [31:0]       modeOut,
  output logic              rxEnabled,
  output logic              txEnabled,
  output logic              clkGenEnabled,
  output logic              irq
);
  logic              swRst;
  logic              rxCapture;
  logic              rxReady, rxOvr, txReady, txUnd;
  logic              rxOvrSet, txUndSet;
  logic [31:0]       rhrReg, thrReg, modeReg, maskReg;
  logic [NUM_CH-1:0] rxChFlag, txChFlag;

  assign swRst     = strobes.cmdWr && wdata[CMD_RESET];
  assign rxCapture = rxWordValid && rxEnabled;
  assign rxOvrSet  = (rxCapture && rxReady && !strobes.rhrRd) || (|rxOvrChIn)
                   || (strobes.setWr && wdata[ST_RXOVR]);
  assign txUndSet  = (txTake && txEnabled && txReady) || (|txUndChIn)
                   || (strobes.setWr && wdata[ST_TXUND]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxEnabled <= 1'b0; txEnabled <= 1'b0; clkGenEnabled <= 1'b0;
      rxReady <= 1'b0; rxOvr <= 1'b0; txReady <= 1'b1; txUnd <= 1'b0;
      rhrReg <= '0; thrReg <= '0; modeReg <= '0; maskReg <= '0;
    end else if (swRst) begin
      rxEnabled <= 1'b0; txEnabled <= 1'b0; clkGenEnabled <= 1'b0;
      rxReady <= 1'b0; rxOvr <= 1'b0; txReady <= 1'b1; txUnd <= 1'b0;
      rhrReg <= '0; thrReg <= '0; modeReg <= '0; maskReg <= '0;
    end else begin
      if (strobes.cmdWr) begin
        if (wdata[CMD_RXOFF])     rxEnabled <= 1'b0;
        else if (wdata[CMD_RXON]) rxEnabled <= 1'b1;
        if (wdata[CMD_CKOFF])     clkGenEnabled <= 1'b0;
        else if (wdata[CMD_CKON]) clkGenEnabled <= 1'b1;
        if (wdata[CMD_TXOFF])     txEnabled <= 1'b0;
        else if (wdata[CMD_TXON]) txEnabled <= 1'b1;
      end
      if (strobes.modeWr) modeReg <= wdata;
      if (strobes.ienWr)       maskReg <= maskReg | (wdata & IRQ_BITS);
      else if (strobes.idisWr) maskReg <= maskReg & ~wdata;

      if (rxCapture) begin
        rhrReg  <= rxWordIn;
        rxReady <= 1'b1;
      end else if (strobes.rhrRd) begin
        rxReady <= 1'b0;
      end

      if (strobes.thrWr) begin
        thrReg  <= wdata;
        txReady <= 1'b0;
      end else if (txTake && txEnabled) begin
        txReady <= 1'b1;
      end

      if (rxOvrSet) rxOvr <= 1'b1;
      else if (strobes.clrWr && wdata[ST_RXOVR]) rxOvr <= 1'b0;
      if (txUndSet) txUnd <= 1'b1;
      else if (strobes.clrWr && wdata[ST_TXUND]) txUnd <= 1'b0;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN || swRst) begin
        rxChFlag[c] <= 1'b0;
        txChFlag[c] <= 1'b0;
      end else begin
        if (rxOvrChIn[c] || (strobes.setWr && wdata[RXCH_LSB+c]))
          rxChFlag[c] <= 1'b1;
        else if (strobes.clrWr && wdata[RXCH_LSB+c])
          rxChFlag[c] <= 1'b0;
        if (txUndChIn[c] || (strobes.setWr && wdata[TXCH_LSB+c]))
          txChFlag[c] <= 1'b1;
        else if (strobes.clrWr && wdata[TXCH_LSB+c])
          txChFlag[c] <= 1'b0;
      end
    end
  end

  always_comb begin
    statusVec                      = '0;
    statusVec[ST_RXEN]             = rxEnabled;
    statusVec[ST_RXRDY]            = rxReady;
    statusVec[ST_RXOVR]            = rxOvr;
    statusVec[ST_TXEN]             = txEnabled;
    statusVec[ST_TXRDY]            = txReady;
    statusVec[ST_TXUND]            = txUnd;
    statusVec[RXCH_LSB +: NUM_CH]  = rxChFlag;
    statusVec[TXCH_LSB +: NUM_CH]  = txChFlag;
  end

  always_comb begin
    unique case (strobes.rdSel)
      RD_MODE:    rdata = modeReg;
      RD_STATUS:  rdata = statusVec;
      RD_MASK:    rdata = maskReg;
      RD_RHR:     rdata = rhrReg;
      RD_VERSION: rdata = VERSION;
      default:    rdata = '0;
    endcase
  end

  assign irq     = |(statusVec & maskReg);
  assign txWord  = thrReg;
  assign modeOut = modeReg;
endmodule

// File: rtl/audio_port_regs.sv
module audio_port_regs
  import aport_pkg::*;
#(
  parameter int          ADDR_W  = 6,
  parameter int          NUM_CH  = 8,
  parameter logic [31:0] VERSION = 32'h0000_0210
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              rxWordValid,
  input  logic [31:0]       rxWordIn,
  input  logic [NUM_CH-1:0] rxOvrChIn,
  input  logic              txTake,
  input  logic [NUM_CH-1:0] txUndChIn,
  output logic [31:0]       txWord,
  output logic [31:0]       modeOut,
  output logic              rxEnabled,
  output logic              txEnabled,
  output logic              clkGenEnabled,
  output logic              irq
);
  regStrobes_t strobes;
  logic [31:0] statusVec;

  aport_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr), .strobes(strobes)
  );

  aport_datapath #(.NUM_CH(NUM_CH), .VERSION(VERSION)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wdata(busWdata),
    .rxWordValid(rxWordValid), .rxWordIn(rxWordIn), .rxOvrChIn(rxOvrChIn),
    .txTake(txTake), .txUndChIn(txUndChIn), .rdata(busRdata),
    .statusVec(statusVec), .txWord(txWord), .modeOut(modeOut),
    .rxEnabled(rxEnabled), .txEnabled(txEnabled),
    .clkGenEnabled(clkGenEnabled), .irq(irq)
  );
endmodule

// File: rtl/aport_regs_chk.sv
module aport_regs_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic [31:0]       busRdata,
  input logic              rxWordValid,
  input logic              rxEnabled,
  input logic [31:0]       statusVec,
  input logic              irq
);
  logic cmdWr, rhrRd, thrWr, badRd;
  assign cmdWr = busSel && busWrite && (busAddr == ADDR_W'(6'h00));
  assign rhrRd = busSel && !busWrite && (busAddr == ADDR_W'(6'h20));
  assign thrWr = busSel && busWrite && (busAddr == ADDR_W'(6'h24));
  assign badRd = busSel && !busWrite && (busAddr > ADDR_W'(6'h28));

  // R4
  dis_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && busWdata[1:0] == 2'b11) |=> !rxEnabled);

  // R12
  sw_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && busWdata[7]) |=> (statusVec == 32'h0000_0020 && !irq));

  // R5
  rhr_consume_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rhrRd && !rxWordValid) |=> !statusVec[1]);

  // R10
  thr_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    thrWr |=> !statusVec[5]);

  // R6
  overrun_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxWordValid && rxEnabled && statusVec[1] && !busSel) |=> statusVec[2]);

  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    badRd |-> busRdata == 32'h0);

  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (statusVec & 32'h0000_0066) != 32'h0);
endmodule

bind audio_port_regs aport_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
  .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
  .rxWordValid(rxWordValid), .rxEnabled(rxEnabled),
  .statusVec(statusVec), .irq(irq)
);

// File: tb/audio_port_regs_tb.sv
module audio_port_regs_tb;
  localparam int          ADDR_W  = 6;
  localparam int          NUM_CH  = 8;
  localparam logic [31:0] VERSION = 32'h0000_0210;

  localparam logic [5:0] A_CMD = 6'h00, A_MODE = 6'h04, A_STAT = 6'h08,
    A_CLR = 6'h0C, A_SET = 6'h10, A_IEN = 6'h14, A_IDIS = 6'h18,
    A_MASK = 6'h1C, A_RHR = 6'h20, A_THR = 6'h24, A_VER = 6'h28;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWrite = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic rxWordValid = 1'b0;
  logic [31:0] rxWordIn = '0;
  logic [NUM_CH-1:0] rxOvrChIn = '0, txUndChIn = '0;
  logic txTake = 1'b0;
  logic [31:0] txWord, modeOut;
  logic rxEnabled, txEnabled, clkGenEnabled, irq;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  logic [31:0] expQ[$];
  string       tagQ[$];

  always #4 clk = ~clk;

  audio_port_regs #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .VERSION(VERSION)) u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .rxWordValid(rxWordValid), .rxWordIn(rxWordIn), .rxOvrChIn(rxOvrChIn),
    .txTake(txTake), .txUndChIn(txUndChIn), .txWord(txWord),
    .modeOut(modeOut), .rxEnabled(rxEnabled), .txEnabled(txEnabled),
    .clkGenEnabled(clkGenEnabled), .irq(irq)
  );

  // monitor: pops expected read data as reads appear on the bus
  always @(negedge clk) begin
    if (busSel && !busWrite) begin
      if (expQ.size() == 0) begin
        testsFailed++;
        $display("FAIL unexpected read: got %h exp none", busRdata);
      end else begin
        automatic logic [31:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        testsRun++;
        if (busRdata !== e) begin
          testsFailed++;
          $display("FAIL %s: got %h exp %h", t, busRdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rdExp(input logic [5:0] a, input logic [31:0] e, input string t);
    expQ.push_back(e);
    tagQ.push_back(t);
    @(posedge clk); #1;
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    @(posedge clk); #1;
    busSel = 1'b0;
  endtask

  task automatic portChk(input logic [31:0] got, input logic [31:0] e, input string t);
    @(negedge clk);
    testsRun++;
    if (got !== e) begin
      testsFailed++;
      $display("FAIL %s: got %h exp %h", t, got, e);
    end
  endtask

  task automatic rxPulse(input logic [31:0] d);
    @(posedge clk); #1;
    rxWordValid = 1'b1; rxWordIn = d;
    @(posedge clk); #1;
    rxWordValid = 1'b0;
  endtask

  task automatic takePulse();
    @(posedge clk); #1; txTake = 1'b1;
    @(posedge clk); #1; txTake = 1'b0;
  endtask

  task automatic chPulse(input logic [7:0] rxm, input logic [7:0] txm);
    @(posedge clk); #1; rxOvrChIn = rxm; txUndChIn = txm;
    @(posedge clk); #1; rxOvrChIn = '0; txUndChIn = '0;
  endtask

  task automatic finishRun();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog: got timeout exp completion");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset values
    rdExp(A_STAT, 32'h0000_0020, "R1 status after reset");
    rdExp(A_MASK, 32'h0, "R1 mask after reset");
    rdExp(A_MODE, 32'h0, "R1 mode after reset");
    portChk({29'b0, rxEnabled, txEnabled, irq}, 32'h0, "R1 enables and irq low");
    // R11 version
    rdExp(A_VER, VERSION, "R11 version");

    // R2 mode
    wr(A_MODE, 32'hDEAD_BEEF);
    rdExp(A_MODE, 32'hDEAD_BEEF, "R2 mode readback");
    portChk(modeOut, 32'hDEAD_BEEF, "R2 modeOut");

    // R3 enables
    wr(A_CMD, 32'h15);
    rdExp(A_STAT, 32'h0000_0031, "R3 rx/tx enabled status");
    portChk({31'b0, clkGenEnabled}, 32'h1, "R3 clock generator enabled");

    // R4 disable wins
    wr(A_CMD, 32'h0C);
    portChk({31'b0, clkGenEnabled}, 32'h0, "R4 clock enable+disable");
    wr(A_CMD, 32'h03);
    rdExp(A_STAT, 32'h0000_0030, "R4 receiver enable+disable");
    portChk({31'b0, rxEnabled}, 32'h0, "R4 rxEnabled low");

    // R5 ignored while disabled
    rxPulse(32'h5555_AAAA);
    rdExp(A_STAT, 32'h0000_0030, "R5 word ignored while disabled");
    rdExp(A_RHR, 32'h0, "R5 holding untouched while disabled");

    // R5 capture and consume
    wr(A_CMD, 32'h01);
    rxPulse(32'h1234_5678);
    rdExp(A_STAT, 32'h0000_0033, "R5 receive ready set");
    rdExp(A_RHR, 32'h1234_5678, "R5 holding word");
    rdExp(A_STAT, 32'h0000_0031, "R5 receive ready cleared by read");

    // R6 overrun
    rxPulse(32'h0000_00A1);
    rxPulse(32'h0000_00B2);
    rdExp(A_STAT, 32'h0000_0037, "R6 overrun latched");
    portChk({31'b0, irq}, 32'h0, "R9 irq low with empty mask");
    // R9 mask
    wr(A_IEN, 32'hFFFF_FF04);
    rdExp(A_MASK, 32'h0000_0004, "R9 mask limited to interrupt bits");
    portChk({31'b0, irq}, 32'h1, "R9 irq on overrun");
    wr(A_CLR, 32'h04);
    rdExp(A_STAT, 32'h0000_0033, "R7 clear summary only");
    portChk({31'b0, irq}, 32'h0, "R9 irq drops after clear");
    rdExp(A_RHR, 32'h0000_00B2, "R6 newest word kept");
    rdExp(A_STAT, 32'h0000_0031, "R5 consumed");

    // R7 per-channel
    chPulse(8'h81, 8'h00);
    rdExp(A_STAT, 32'h0000_8135, "R7 per-channel overrun + summary");
    portChk({31'b0, irq}, 32'h1, "R9 irq from channel overrun");
    wr(A_CLR, 32'h0000_0104);
    rdExp(A_STAT, 32'h0000_8031, "R7 masked channel cleared, other kept");
    portChk({31'b0, irq}, 32'h0, "R9 unmaskable channel bit no irq");
    wr(A_CLR, 32'h0000_8000);
    rdExp(A_STAT, 32'h0000_0031, "R7 remaining channel cleared");

    // R8 set alias
    wr(A_SET, 32'h0040_0040);
    rdExp(A_STAT, 32'h0040_0071, "R8 set alias");
    wr(A_IEN, 32'h40);
    rdExp(A_MASK, 32'h0000_0044, "R9 mask accumulates");
    portChk({31'b0, irq}, 32'h1, "R9 irq on underrun");
    wr(A_IDIS, 32'h44);
    rdExp(A_MASK, 32'h0, "R9 disable clears mask");
    portChk({31'b0, irq}, 32'h0, "R9 irq low after disable");
    wr(A_CLR, 32'h0040_0040);
    rdExp(A_STAT, 32'h0000_0031, "R7 clear underrun flags");

    // R10 transmit
    wr(A_THR, 32'hCAFE_F00D);
    rdExp(A_STAT, 32'h0000_0011, "R10 transmit ready cleared");
    portChk(txWord, 32'hCAFE_F00D, "R10 txWord");
    takePulse();
    rdExp(A_STAT, 32'h0000_0031, "R10 word taken");
    takePulse();
    rdExp(A_STAT, 32'h0000_0071, "R10 underrun on empty take");
    wr(A_CLR, 32'h40);
    chPulse(8'h00, 8'h04);
    rdExp(A_STAT, 32'h0040_0071, "R7 per-channel underrun");

    // R11 zero reads
    rdExp(6'h2C, 32'h0, "R11 unmapped read");
    rdExp(A_CMD, 32'h0, "R11 write-only read");
    rdExp(6'h09, 32'h0, "R11 misaligned read");
    rdExp(A_THR, 32'h0, "R11 transmit holding write-only");

    // R12 software reset
    wr(A_IEN, 32'h02);
    wr(A_CMD, 32'h95);
    rdExp(A_STAT, 32'h0000_0020, "R12 status after soft reset");
    rdExp(A_MASK, 32'h0, "R12 mask after soft reset");
    rdExp(A_MODE, 32'h0, "R12 mode after soft reset");
    portChk({29'b0, rxEnabled, txEnabled, clkGenEnabled}, 32'h0, "R12 enables low");

    repeat (2) @(posedge clk);
    finishRun();
  end
endmodule